// File: doc/BRIEF.md
# Absolute and difference-or-zero unit

This block is a small integer execution unit for a 32-bit datapath. Each cycle it accepts an opcode, two register operands and a 16-bit immediate. One cycle later it presents one of four results: the absolute value of operand A, the negated absolute value of A, a register "difference or zero", or the same operation against the sign-extended immediate. The difference-or-zero result is zero when A is greater than the second operand in signed terms. Otherwise it is the second operand minus A, formed as the complement of A plus the second operand plus one.

Beside the result, the unit reports an overflow flag when overflow detection is enabled. It keeps a sticky summary-overflow bit that only an explicit clear input resets. When the record flag is set, it also produces a 4-bit condition field that classifies the signed result and carries the summary overflow. Register-file access, decode and pipeline control belong to the surrounding core.

Top module: `absdoz_unit`

## Requirements
- R1: With opcode 2'b00 (absolute) and A not equal to 0x8000_0000, the result one cycle later is the magnitude of A taken as a signed value.
- R2: With opcode 2'b00 and A equal to 0x8000_0000, the result is 0x8000_0000, and the overflow flag equals the overflow-enable input of that cycle.
- R3: With opcode 2'b01 (negative absolute), the result is minus the magnitude of A, 0x8000_0000 maps to 0x8000_0000, and the overflow flag is never set.
- R4: With opcode 2'b10 (register difference-or-zero), the result is zero if A > B in signed terms, else B - A modulo 2^32.
- R5: With opcode 2'b11 (immediate difference-or-zero), the rule of R4 applies with the 16-bit immediate sign-extended to 32 bits in place of B.
- R6: For opcodes 2'b10 and 2'b11 with overflow-enable high, the overflow flag is set exactly when A is not greater than the second operand and B - A overflows as a signed 32-bit subtraction.
- R7: With overflow-enable low, the overflow flag is zero for every opcode.
- R8: The summary-overflow output is set in every cycle whose overflow flag is set, and it stays set until a cycle with the clear input high and no new overflow, which returns it to zero.
- R9: With the record flag high, the condition field is {negative, positive, zero, summary overflow}, bit 3 down to bit 0, from the signed result and the updated summary overflow. With the record flag low it is 4'b0000.
- R10: While reset is asserted, the result, the overflow flag, the summary overflow and the condition field are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation select: 00 abs, 01 negative abs, 10 register doz, 11 immediate doz |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| imm_i | input | 16 | Signed immediate for the immediate form |
| oe_i | input | 1 | Overflow-detection enable |
| rec_i | input | 1 | Record flag: produce the condition field |
| so_clr_i | input | 1 | Clears the summary-overflow bit |
| result_o | output | 32 | Registered result |
| ov_o | output | 1 | Registered overflow flag |
| so_o | output | 1 | Sticky summary overflow |
| cr_o | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The checker assumes that a new set of inputs is presented on every clock edge and held stable around it. It also assumes the opcode is always one of the four defined codes, so each registered output corresponds to the inputs of exactly one previous edge. The bench changes its inputs only on the falling edge and draws opcodes from the two-bit space alone, which keeps it within that assumption. Random operands are biased toward 0x8000_0000, 0x7FFF_FFFF, zero and equal pairs, so that the saturation, overflow and equality boundaries come up often.

// File: rtl/absdoz_pkg.sv
package absdoz_pkg;
    typedef enum logic [1:0] {
        OP_ABS  = 2'b00,
        OP_NABS = 2'b01,
        OP_DOZ  = 2'b10,
        OP_DOZI = 2'b11
    } absdoz_op_e;

    localparam int unsigned CR_W = 4;
endpackage

// File: rtl/absdoz_mag.sv
module absdoz_mag #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic         negate,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] mag;

    always_comb begin
        mag = a[W-1] ? (~a + 1'b1) : a;
        res = negate ? (~mag + 1'b1) : mag;
        ovf = !negate && (a == MINV);
    end
endmodule

// File: rtl/absdoz_diff.sv
module absdoz_diff #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         ovf
);
    logic [W-1:0] diff;
    logic         a_gt;

    always_comb begin
        diff = ~a + b + 1'b1;
        a_gt = $signed(a) > $signed(b);
        res  = a_gt ? '0 : diff;
        ovf  = !a_gt && (a[W-1] != b[W-1]) && (diff[W-1] != b[W-1]);
    end
endmodule

// File: rtl/absdoz_cond.sv
module absdoz_cond #(
    parameter int unsigned W    = 32,
    parameter int unsigned CR_W = 4
) (
    input  logic [W-1:0]    res,
    input  logic            so,
    input  logic            rec,
    output logic [CR_W-1:0] cr
);
    logic neg, zer;

    always_comb begin
        neg = res[W-1];
        zer = (res == '0);
        cr  = '0;
        if (rec) begin
            cr[3] = neg;
            cr[2] = !neg && !zer;
            cr[1] = zer;
            cr[0] = so;
        end
    end
endmodule

// File: rtl/absdoz_unit.sv
module absdoz_unit
    import absdoz_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             oe_i,
    input  logic             rec_i,
    input  logic             so_clr_i,
    output logic [W-1:0]     result_o,
    output logic             ov_o,
    output logic             so_o,
    output logic [CR_W-1:0]  cr_o
);
    localparam int unsigned EXT_W = W - IMM_W;

    typedef struct packed {
        logic [W-1:0]    result;
        logic            ov;
        logic            so;
        logic [CR_W-1:0] cr;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0]    imm_ext;
    logic [W-1:0]    rhs;
    logic [W-1:0]    mag_res, diff_res;
    logic            mag_ovf, diff_ovf;
    logic [CR_W-1:0] cr_new;
    absdoz_op_e      op;

    assign op      = absdoz_op_e'(op_i);
    assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

    generate
        if (EXT_W > 0) begin : g_imm_mux
            assign rhs = (op == OP_DOZI) ? imm_ext : b_i;
        end else begin : g_no_imm
            assign rhs = b_i;
        end
    endgenerate

    absdoz_mag #(.W(W)) u_mag (
        .a      (a_i),
        .negate (op == OP_NABS),
        .res    (mag_res),
        .ovf    (mag_ovf)
    );

    absdoz_diff #(.W(W)) u_diff (
        .a   (a_i),
        .b   (rhs),
        .res (diff_res),
        .ovf (diff_ovf)
    );

    absdoz_cond #(.W(W), .CR_W(CR_W)) u_cond (
        .res (st_d.result),
        .so  (st_d.so),
        .rec (rec_i),
        .cr  (cr_new)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_ABS, OP_NABS: begin
                st_d.result = mag_res;
                st_d.ov     = oe_i && mag_ovf;
            end
            default: begin
                st_d.result = diff_res;
                st_d.ov     = oe_i && diff_ovf;
            end
        endcase
        st_d.so = (st_q.so && !so_clr_i) || st_d.ov;
        st_d.cr = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q.result <= st_d.result;
            st_q.ov     <= st_d.ov;
            st_q.so     <= st_d.so;
            st_q.cr     <= cr_new;
        end
    end

    assign result_o = st_q.result;
    assign ov_o     = st_q.ov;
    assign so_o     = st_q.so;
    assign cr_o     = st_q.cr;
endmodule

// File: rtl/absdoz_unit_chk.sv
module absdoz_unit_chk #(
    parameter int unsigned W     = 32,
    parameter int unsigned IMM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op_i,
    input logic [W-1:0]     a_i,
    input logic [W-1:0]     b_i,
    input logic [IMM_W-1:0] imm_i,
    input logic             oe_i,
    input logic             rec_i,
    input logic             so_clr_i,
    input logic [W-1:0]     result_o,
    input logic             ov_o,
    input logic             so_o,
    input logic [3:0]       cr_o
);
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (result_o == '0 && !ov_o && !so_o && cr_o == '0); // R10
        end
    end

    AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i == 2'b00 && a_i != MINV) |-> !result_o[W-1]); // R1
    AST_ABS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i == 2'b00 && a_i == MINV) |-> (result_o == MINV && ov_o == $past(oe_i))); // R2
    AST_NABS_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i == 2'b01) |-> (!ov_o && (result_o == '0 || result_o[W-1]))); // R3
    AST_DOZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i == 2'b10 && $signed(a_i) > $signed(b_i)) |-> (result_o == '0 && !ov_o)); // R4
    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(oe_i) |-> !ov_o); // R7
    AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(so_o) && !$past(so_clr_i) |-> so_o); // R8
    AST_OV_SETS_SO: assert property (@(posedge clk) disable iff (!rst_n)
        ov_o |-> so_o); // R8
    AST_CR_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(rec_i) |-> ($countones(cr_o[3:1]) == 1 && cr_o[0] == so_o)); // R9
    AST_CR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(rec_i) |-> cr_o == 4'b0000); // R9
endmodule

bind absdoz_unit absdoz_unit_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .imm_i    (imm_i),
    .oe_i     (oe_i),
    .rec_i    (rec_i),
    .so_clr_i (so_clr_i),
    .result_o (result_o),
    .ov_o     (ov_o),
    .so_o     (so_o),
    .cr_o     (cr_o)
);

// File: tb/absdoz_unit_test.sv
module absdoz_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MINV = 32'h8000_0000;
    localparam logic [31:0] MAXV = 32'h7FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [15:0] imm_i = '0;
    logic        oe_i = 1'b0;
    logic        rec_i = 1'b0;
    logic        so_clr_i = 1'b0;
    logic [31:0] result_o;
    logic        ov_o;
    logic        so_o;
    logic [3:0]  cr_o;

    int checks = 0;
    int failures = 0;
    bit so_model = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    absdoz_unit uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .imm_i(imm_i), .oe_i(oe_i), .rec_i(rec_i), .so_clr_i(so_clr_i),
        .result_o(result_o), .ov_o(ov_o), .so_o(so_o), .cr_o(cr_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pick_val();
        int sel = int'($urandom_range(0, 7));
        case (sel)
            0: return MINV;
            1: return MAXV;
            2: return 32'h0;
            3: return 32'hFFFF_FFFF;
            default: return $urandom();
        endcase
    endfunction

    task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input bit oe, input bit rec, input bit clr);
        logic [31:0] rhs, mag, exp_res;
        bit raw_ov, exp_ov;
        logic [3:0] exp_cr;
        string rtag, otag;
        op_i = op; a_i = a; b_i = b; imm_i = imm; oe_i = oe; rec_i = rec; so_clr_i = clr;
        rhs = (op == 2'b11) ? {{16{imm[15]}}, imm} : b;
        mag = a[31] ? -a : a;
        raw_ov = 1'b0;
        case (op)
            2'b00: begin exp_res = mag; raw_ov = (a == MINV); rtag = (a == MINV) ? "R2" : "R1"; otag = "R2"; end
            2'b01: begin exp_res = -mag; rtag = "R3"; otag = "R3"; end
            default: begin
                if ($signed(a) > $signed(rhs)) exp_res = 32'h0;
                else begin
                    exp_res = rhs - a;
                    raw_ov = (a[31] != rhs[31]) && (exp_res[31] != rhs[31]);
                end
                rtag = (op == 2'b10) ? "R4" : "R5";
                otag = "R6";
            end
        endcase
        if (!oe) otag = "R7";
        exp_ov = oe && raw_ov;
        so_model = (so_model && !clr) || exp_ov;
        exp_cr = 4'b0000;
        if (rec) exp_cr = {exp_res[31], !exp_res[31] && exp_res != 0, exp_res == 0, so_model};
        @(posedge clk);
        @(negedge clk);
        check(result_o == exp_res, rtag, result_o, exp_res);
        check(ov_o == exp_ov, otag, {31'b0, ov_o}, {31'b0, exp_ov});
        check(so_o == so_model, "R8", {31'b0, so_o}, {31'b0, so_model});
        check(cr_o == exp_cr, "R9", {28'b0, cr_o}, {28'b0, exp_cr});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        check(result_o == 0 && !ov_o && !so_o && cr_o == 0, "R10", result_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        apply(2'b00, 32'hFFFF_FFF6, 0, 0, 1, 1, 0);      // R1 negative input
        apply(2'b00, 32'd77, 0, 0, 1, 0, 0);             // R1 positive input
        apply(2'b00, MINV, 0, 0, 0, 1, 0);               // R2 saturate, oe low
        apply(2'b00, MINV, 0, 0, 1, 1, 0);               // R2 saturate, sets overflow
        apply(2'b01, 32'd5, 0, 0, 1, 1, 0);              // R3 with sticky SO held
        apply(2'b01, MINV, 0, 0, 1, 1, 1);               // R3 and R8 clear
        apply(2'b01, 32'h0, 0, 0, 1, 1, 0);              // R3 zero
        apply(2'b10, 32'd9, 32'd4, 0, 1, 1, 0);          // R4 A > B gives zero
        apply(2'b10, 32'd4, 32'd9, 0, 1, 1, 0);          // R4 difference
        apply(2'b10, 32'd4, 32'd4, 0, 1, 1, 0);          // R4 equal operands
        apply(2'b10, MINV, MAXV, 0, 1, 1, 0);            // R6 overflow
        apply(2'b10, 32'hFFFF_FFFF, MAXV, 0, 1, 1, 1);   // R6 overflow with clear, R8
        apply(2'b10, MINV, MAXV, 0, 0, 0, 1);            // R7 no overflow when disabled
        apply(2'b11, 32'hFFFF_FFF0, 0, 16'hFFF8, 1, 1, 0); // R5 negative immediate
        apply(2'b11, 32'd3, 32'hDEAD_BEEF, 16'h8000, 1, 1, 0); // R5 A > imm
        apply(2'b11, MINV, 0, 16'h7FFF, 1, 1, 0);        // R5 large difference

        for (int i = 0; i < 600; i++) begin
            apply(2'($urandom_range(0, 3)), pick_val(), pick_val(), 16'($urandom()),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  $urandom_range(0, 9) == 0);
        end

        rst_n = 1'b0;
        #1;
        // R10 asynchronous reset clears everything
        check(result_o == 0 && !ov_o && !so_o && cr_o == 0, "R10", result_o, 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule